// File: doc/BRIEF.md
# Dual-Channel DAC Register Target on a Two-Wire Serial Bus

This block is a write-only target on a two-wire serial bus (I2C). It holds the digital codes for two 8-bit converter channels together with a power-down flag. A bus master sends the block's address, then a command byte, then an optional data byte. The command byte picks the channel and carries the power-down and reset requests. It may be sent again, each time followed by another data byte, any number of times in one transfer.

Every channel has two registers. The first is an input latch, written as data bytes arrive. The second is an output latch, which drives the converter. Output latches change only on the STOP condition that closes an addressed transfer, and then both change in the same clock cycle. The power-down and reset requests also wait for that STOP. Bus lines arrive raw and are sampled on the system clock. The only thing the block drives on the bus is an open-drain pull-low enable for the data line.

The block has no streaming interface. Every port is a plain control or status pin, so back-pressure rules do not apply.

Top module: `dac_pair_i2c_target`

## Requirements
- R1: The 7-bit target address is the fixed upper part `ADDR_HI` (default 3'b010) followed by the four `addr_pins_i` bits. An address byte whose upper seven bits equal this address and whose bit 0 is 0 is acknowledged. Any other address is not acknowledged.
- R2: An address byte that matches but has bit 0 (read/write) set to 1 is not acknowledged. The rest of that transfer has no effect on the outputs.
- R3: For every accepted byte, `sda_low_o` rises after the SCL falling edge that ends the eighth bit. It stays high through the ninth SCL pulse and is released after the SCL falling edge that ends that pulse.
- R4: Command byte fields are as follows. Bits 7..5 are reserved and ignored. Bit 4 is the reset request. Bit 3 is the power-down request. Bits 2..1 are don't-care. Bit 0 is the channel select.
- R5: A data byte that follows a command byte is written to the input latch of the channel named by that command's bit 0 (0 selects channel 0, 1 selects channel 1). `ch0_o` and `ch1_o` do not change before the STOP.
- R6: On STOP after an addressed transfer, both input latches are copied to `ch0_o` and `ch1_o` in the same clock cycle.
- R7: `pwrdn_o` takes the power-down bit of the last command byte, and only at the STOP. A data byte in the same transfer is still committed.
- R8: If the last command byte had the reset bit set, the STOP clears both input and output latches to zero. The reset takes precedence over data written in that transfer.
- R9: If a command byte is the last byte before STOP, only its reset and power-down bits have an effect. Its channel select and other bits change no latch.
- R10: Several command/data pairs may be sent in one transfer, and a later write to a channel replaces an earlier one. A repeated START drops a partly received byte. Pairs that were completed are kept and committed at the later STOP.
- R11: After reset, `ch0_o`, `ch1_o`, `pwrdn_o` and `sda_low_o` are all 0.
- R12: Traffic addressed elsewhere gets no acknowledge on any byte and leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (wired-AND level) |
| addr_pins_i | input | 4 | Low four address bits |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| ch0_o | output | 8 | Channel 0 output latch |
| ch1_o | output | 8 | Channel 1 output latch |
| pwrdn_o | output | 1 | Power-down flag |

## Verification
The checker relies on these conditions holding at the bus:
- Each SCL high phase and each SCL low phase lasts longer than the synchronizer delay of a few clocks.
- SDA moves while SCL is high only to signal START or STOP.

Under these conditions, pull-low changes are only ever seen while SCL is low, and an output latch moves only in the cycle after a detected STOP. The stimulus holds every bus level for ten clocks per quarter bit. It changes the master's SDA only in the middle of SCL low phases, except for the START, repeated START and STOP sequences. The data line is modelled as the wired AND of the master's drive and the block's pull-low.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int NCH = 2;
  localparam int CMD_RST_BIT = 4;
  localparam int CMD_PD_BIT  = 3;
  localparam int CMD_SEL_BIT = 0;

  typedef enum logic [1:0] {
    RB_IDLE,
    RB_ADDR,
    RB_CMD,
    RB_DATA
  } rb_state_t;
endpackage

// File: rtl/dpt_bus_sync.sv
module dpt_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchronizer flops plus one history flop per line
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign scl_q = scl_sh[STAGES];
  assign sda_s = sda_sh[STAGES-1];
  assign sda_q = sda_sh[STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dpt_byte_rx.sv
module dpt_byte_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          ack_grant,
  output logic          byte_vld,
  output logic [DW-1:0] byte_q,
  output logic          sda_low
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ACK_WAIT = CW'(DW);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW + 1);

  logic          active;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      sda_low  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (start_det) begin
        active  <= 1'b1;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        active  <= 1'b0;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else if (active) begin
        if (scl_rise && bitcnt < ACK_WAIT) begin
          shreg  <= {shreg[DW-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) byte_vld <= 1'b1;
        end else if (scl_fall && bitcnt == ACK_WAIT) begin
          bitcnt  <= ACK_SLOT;
          sda_low <= ack_grant;
          if (!ack_grant) active <= 1'b0;
        end else if (scl_fall && bitcnt == ACK_SLOT) begin
          bitcnt  <= '0;
          sda_low <= 1'b0;
        end
      end
    end
  end

  assign byte_q = shreg;
endmodule

// File: rtl/dpt_reg_bank.sv
module dpt_reg_bank
  import dpt_pkg::*;
#(
  parameter int DW = 8,
  parameter int ADDR_W = 7,
  parameter int PIN_W = 4,
  parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI = 3'b010
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic                    byte_vld,
  input  logic [DW-1:0]           byte_q,
  input  logic [PIN_W-1:0]        addr_pins,
  output logic                    ack_grant,
  output logic [NCH-1:0][DW-1:0]  out_q,
  output logic                    pwrdn,
  output logic                    rst_pend
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

  rb_state_t             st;
  logic [NCH-1:0][DW-1:0] in_q;
  logic [SW-1:0]         sel;
  logic                  armed, cmd_seen, pd_pend;
  logic                  addr_hit;

  assign addr_hit = (byte_q[DW-1:1] == {ADDR_HI, addr_pins}) && !byte_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RB_IDLE;
      in_q      <= '0;
      out_q     <= '0;
      sel       <= '0;
      armed     <= 1'b0;
      cmd_seen  <= 1'b0;
      pd_pend   <= 1'b0;
      rst_pend  <= 1'b0;
      pwrdn     <= 1'b0;
      ack_grant <= 1'b0;
    end else if (start_det) begin
      st        <= RB_ADDR;
      ack_grant <= 1'b0;
    end else if (stop_det) begin
      st        <= RB_IDLE;
      ack_grant <= 1'b0;
      if (armed) begin
        for (int c = 0; c < NCH; c++) begin
          if (rst_pend) begin
            in_q[c]  <= '0;
            out_q[c] <= '0;
          end else begin
            out_q[c] <= in_q[c];
          end
        end
        if (cmd_seen) pwrdn <= pd_pend;
        armed    <= 1'b0;
        cmd_seen <= 1'b0;
        rst_pend <= 1'b0;
      end
    end else if (byte_vld) begin
      unique case (st)
        RB_ADDR: begin
          ack_grant <= addr_hit;
          st        <= addr_hit ? RB_CMD : RB_IDLE;
          if (addr_hit) armed <= 1'b1;
        end
        RB_CMD: begin
          ack_grant <= 1'b1;
          pd_pend   <= byte_q[CMD_PD_BIT];
          rst_pend  <= byte_q[CMD_RST_BIT];
          sel       <= byte_q[CMD_SEL_BIT +: SW];
          cmd_seen  <= 1'b1;
          st        <= RB_DATA;
        end
        RB_DATA: begin
          ack_grant <= 1'b1;
          in_q[sel] <= byte_q;
          st        <= RB_CMD;
        end
        default: ack_grant <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dac_pair_i2c_target.sv
module dac_pair_i2c_target #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [2:0] ADDR_HI = 3'b010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [3:0]    addr_pins_i,
  output logic          sda_low_o,
  output logic [DW-1:0] ch0_o,
  output logic [DW-1:0] ch1_o,
  output logic          pwrdn_o
);
  import dpt_pkg::*;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic byte_vld, ack_grant, rst_pend;
  logic [DW-1:0] byte_q;
  logic [NCH-1:0][DW-1:0] out_q;

  dpt_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dpt_byte_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_grant(ack_grant), .byte_vld(byte_vld), .byte_q(byte_q),
    .sda_low(sda_low_o)
  );

  dpt_reg_bank #(.DW(DW), .ADDR_W(7), .PIN_W(4), .ADDR_HI(ADDR_HI)) u_bank (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_vld(byte_vld), .byte_q(byte_q), .addr_pins(addr_pins_i),
    .ack_grant(ack_grant), .out_q(out_q), .pwrdn(pwrdn_o), .rst_pend(rst_pend)
  );

  assign ch0_o = out_q[0];
  assign ch1_o = out_q[1];
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_low_o,
  input logic [DW-1:0] ch0_o,
  input logic [DW-1:0] ch1_o,
  input logic          pwrdn_o,
  input logic          stop_det,
  input logic          rst_pend
);
  AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl_i);  // R3
  AST_ACK_FREE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_low_o) |-> !scl_i);  // R3
  AST_OUT_HOLD_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_det) |-> ($stable(ch0_o) && $stable(ch1_o)));  // R5
  AST_PWRDN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_det) |-> $stable(pwrdn_o));  // R7
  AST_RST_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_det) && $past(rst_pend)) |-> (ch0_o == '0 && ch1_o == '0));  // R8
endmodule

bind dac_pair_i2c_target dpt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .ch0_o(ch0_o), .ch1_o(ch1_o), .pwrdn_o(pwrdn_o),
  .stop_det(stop_det), .rst_pend(rst_pend)
);

// File: tb/test_dac_pair_i2c_target.sv
`timescale 1ns/1ps
module test_dac_pair_i2c_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] pins = 4'b1011;
  logic sda_low_o, pwrdn_o;
  logic [7:0] ch0_o, ch1_o;
  logic sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  logic [16:0] sb_val[$];
  string       sb_tag[$];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_low_o;

  dac_pair_i2c_target i_dac_pair_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_pins_i(pins), .sda_low_o(sda_low_o), .ch0_o(ch0_o),
    .ch1_o(ch1_o), .pwrdn_o(pwrdn_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    chk(sda_low_o == exp_ack, {tag, " ack"}, 32'(sda_low_o), 32'(exp_ack));
    wq();
    scl = 1'b0; wq();
    if (exp_ack) chk(sda_low_o == 1'b0, "R3 release", 32'(sda_low_o), 0);
  endtask

  // driver side of the scoreboard: close the transfer and push the expectation
  task automatic end_xfer(input logic [7:0] e0, input logic [7:0] e1,
                          input logic epd, input string tag);
    bus_stop();
    sb_val.push_back({epd, e1, e0});
    sb_tag.push_back(tag);
  endtask

  // monitor side: compare outputs once the STOP has been processed
  initial begin
    forever begin
      wait (sb_val.size() != 0);
      repeat (6) @(negedge clk);
      begin
        logic [16:0] e;
        string t;
        e = sb_val.pop_front();
        t = sb_tag.pop_front();
        chk({pwrdn_o, ch1_o, ch0_o} == e, t, 32'({pwrdn_o, ch1_o, ch0_o}), 32'(e));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    chk({sda_low_o, pwrdn_o, ch1_o, ch0_o} == '0, "R11 reset",
        32'({sda_low_o, pwrdn_o, ch1_o, ch0_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5/R6: single write to channel 0, held until STOP
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'h00, 1, "R3 cmd");
    send_byte(8'h5A, 1, "R3 data");
    chk(ch0_o == 8'h00, "R5 no early update", 32'(ch0_o), 0);
    end_xfer(8'h5A, 8'h00, 0, "R6 ch0 commit");

    // R10/R6: both channels in one transfer
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'h00, 1, "R4 cmd ch0");
    send_byte(8'h11, 1, "R5 data");
    send_byte(8'h01, 1, "R4 cmd ch1");
    send_byte(8'h22, 1, "R5 data");
    chk({ch1_o, ch0_o} == 16'h005A, "R5 hold", 32'({ch1_o, ch0_o}), 32'h005A);
    end_xfer(8'h11, 8'h22, 0, "R6 both commit");

    // R12: wrong address, every byte refused
    bus_start();
    send_byte(8'h58, 0, "R12 addr");
    send_byte(8'h00, 0, "R12 cmd");
    send_byte(8'hEE, 0, "R12 data");
    end_xfer(8'h11, 8'h22, 0, "R12 outputs kept");

    // R2: read request refused
    bus_start();
    send_byte(8'h57, 0, "R2 addr");
    send_byte(8'h08, 0, "R2 cmd");
    end_xfer(8'h11, 8'h22, 0, "R2 outputs kept");

    // R7: power-down with data, deferred to STOP
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'h08, 1, "R7 cmd");
    send_byte(8'h33, 1, "R7 data");
    chk(pwrdn_o == 1'b0, "R7 deferred", 32'(pwrdn_o), 0);
    end_xfer(8'h33, 8'h22, 1, "R7 pd with data");

    // R9: lone command, reserved bits and select set, power-down cleared
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'hE7, 1, "R9 cmd");
    end_xfer(8'h33, 8'h22, 0, "R9 command only");

    // R10: repeated START drops partial byte, earlier pair kept
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'h01, 1, "R10 cmd");
    send_byte(8'h44, 1, "R10 data");
    send_byte(8'h00, 1, "R10 cmd");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'h56, 1, "R10 readdr");
    chk({ch1_o, ch0_o} == 16'h2233, "R10 no commit on restart",
        32'({ch1_o, ch0_o}), 32'h2233);
    send_byte(8'h00, 1, "R10 cmd");
    send_byte(8'h55, 1, "R10 data");
    end_xfer(8'h55, 8'h44, 0, "R10 restart");

    // R8: reset beats data written in the same transfer
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'h11, 1, "R8 cmd");
    send_byte(8'h99, 1, "R8 data");
    end_xfer(8'h00, 8'h00, 0, "R8 reset precedence");

    // R8: input latches also cleared (a lone command commits them)
    bus_start();
    send_byte(8'h56, 1, "R1 addr");
    send_byte(8'h00, 1, "R8 cmd");
    end_xfer(8'h00, 8'h00, 0, "R8 inputs cleared");

    // R1: new address pins
    pins = 4'b0000;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(8'h56, 0, "R1 old addr");
    end_xfer(8'h00, 8'h00, 0, "R1 old addr ignored");
    bus_start();
    send_byte(8'h40, 1, "R1 new addr");
    send_byte(8'h01, 1, "R1 cmd");
    send_byte(8'hA5, 1, "R1 data");
    end_xfer(8'h00, 8'hA5, 0, "R1 new addr write");

    // R10: later write to the same channel replaces the earlier one
    bus_start();
    send_byte(8'h40, 1, "R1 addr");
    send_byte(8'h00, 1, "R10 cmd");
    send_byte(8'h01, 1, "R10 data");
    send_byte(8'h00, 1, "R10 cmd");
    send_byte(8'h02, 1, "R10 data");
    end_xfer(8'h02, 8'hA5, 0, "R10 last wins");

    wait (sb_val.size() == 0);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule